// File: doc/BRIEF.md
# Loopback Self-Test Word Generator and Checker

This block runs a loopback self-test across a group of serial lanes. Each lane is a stream of 32-bit words with a valid strobe. Software selects three things in one control word: the transmit lanes that send test words, the single receive lane that is checked, and the data source. The data source is either a fixed 32-bit pattern repeated on every word, or a 32-bit maximal-length pseudo-random sequence. Writing the control word with the enable bit set starts a run.

During a run the block sends a new test word on every clock cycle. The checker holds its own copy of the expected sequence. It moves that copy forward only when a valid word arrives on the selected receive lane. Software reads a status word with two fields. The first is a pass flag, which is set at run start and cleared by the first miscompare. The second is an 11-bit count of the words compared. Clearing the enable bit stops the transmit lanes and freezes both fields so that software can read the final result.

Top module: `lbist_engine`

## Requirements
- R1: A write to control (address 0) with bit 31 set starts a run. It sets the pass flag to 1 and clears the count to 0. It also seeds both the generator sequence and the expected sequence with 32'h1234_5678. This happens whatever the previous state was, including during a run.
- R2: With control bit 30 = 0, the transmitted word starts at the seed on the first cycle after the start. It then follows s' = {s[30:0], s[31]^s[21]^s[1]^s[0]} once per enabled cycle.
- R3: With control bit 30 = 1, every transmitted word equals the pattern register (address 1).
- R4: While enabled, tx_valid[i] is 1 exactly when control bit i (bits 3:0) is set. All enabled lanes carry the same word.
- R5: Only the receive lane given by control bits 17:16 is compared. Each valid word on that lane is checked against the next expected word, and the expected sequence advances only on such words. Words and strobes on the other lanes have no effect.
- R6: The pass flag (status bit 31) drops on the first mismatching word. It stays 0 until a new run starts, even if later words match.
- R7: The count (status bits 10:0) rises by one for each compared word, matching or not. It wraps from 2047 to 0, and the wrap does not affect the pass flag.
- R8: A control write with bit 31 = 0 drives all tx_valid low. The count and the pass flag then hold, whatever arrives on the receive lanes.
- R9: After reset all registers read 0. Control reads back only bits 31, 30, 17:16 and 3:0, and its other bits read 0. Status reads {pass, 20'b0, count}. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 pattern, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| tx_valid | output | 4 | Per-lane transmit strobe |
| tx_data | output | 128 | Transmit words, lane i in bits 32*i+31:32*i |
| rx_valid | input | 4 | Per-lane receive strobe |
| rx_data | input | 128 | Receive words, lane i in bits 32*i+31:32*i |

## Verification
Several rules are checked by assertions on every cycle:
- the stickiness of the pass flag between starts;
- the single-step count on each compared word;
- the freeze while disabled;
- the restart values after a start;
- transmit strobes staying inside the mask;
- the fixed-pattern word matching the pattern register;
- the generator state never being zero.

Only the bench scenarios can show the following:
- the actual pseudo-random word sequence;
- that gaps in the receive strobe keep the checker in step;
- that unselected lanes are ignored;
- the 11-bit wrap;
- the register read-back layout.

// File: rtl/lbist_pkg.sv
// Shared constants and the sequence step function for the loopback self-test.
// Assumes 32-bit lane words and 32-bit register accesses.
package lbist_pkg;
    localparam int          WORD_W     = 32;
    localparam int          CNT_W      = 11;
    localparam logic [1:0]  ADDR_CTRL  = 2'd0;
    localparam logic [1:0]  ADDR_PAT   = 2'd1;
    localparam logic [1:0]  ADDR_STAT  = 2'd2;
    localparam int          BIT_EN     = 31;
    localparam int          BIT_FIXED  = 30;
    localparam int          SEL_LSB    = 16;
    localparam logic [31:0] SEQ_SEED   = 32'h1234_5678;

    // One step of the x^32+x^22+x^2+x+1 shift sequence.
    function automatic logic [31:0] seq_step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction
endpackage

// File: rtl/lbist_regs.sv
// Control and pattern registers. Produces a one-cycle start pulse when the
// control word is written with the enable bit set. Assumes NLANES <= 16.
module lbist_regs
    import lbist_pkg::*;
#(
    parameter int NLANES = 4,
    parameter int SELW   = (NLANES > 1) ? $clog2(NLANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    output logic              en,
    output logic              fixed,
    output logic [SELW-1:0]   rxsel,
    output logic [NLANES-1:0] txmask,
    output logic [31:0]       pattern,
    output logic              start
);
    logic ctrl_wr;
    logic unused_wbits;

    assign ctrl_wr      = wr_en && (addr == ADDR_CTRL);
    assign start        = ctrl_wr && wdata[BIT_EN];
    assign unused_wbits = ^{wdata[29:SEL_LSB+SELW], wdata[SEL_LSB-1:NLANES]};

    // Capture control fields and the pattern word on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            fixed   <= 1'b0;
            rxsel   <= '0;
            txmask  <= '0;
            pattern <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_CTRL) begin
                en     <= wdata[BIT_EN];
                fixed  <= wdata[BIT_FIXED];
                rxsel  <= wdata[SEL_LSB +: SELW];
                txmask <= wdata[NLANES-1:0];
            end else if (addr == ADDR_PAT) begin
                pattern <= wdata;
            end
        end
    end

    // R1: a start leaves the block enabled on the next cycle.
    a_r1_start_enables: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> en);
endmodule

// File: rtl/lbist_gen.sv
// Test word generator. Holds the sequence state, reseeds on start and steps
// once per enabled cycle. All masked lanes carry the same word.
module lbist_gen
    import lbist_pkg::*;
#(
    parameter int NLANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     en,
    input  logic                     fixed,
    input  logic [NLANES-1:0]        txmask,
    input  logic [31:0]              pattern,
    output logic [NLANES-1:0]        tx_valid,
    output logic [NLANES*WORD_W-1:0] tx_data
);
    logic [31:0] state;
    logic [31:0] word;

    // Advance the sequence state while a run is active.
    always_ff @(posedge clk) begin
        if (!rst_n || start) state <= SEQ_SEED;
        else if (en)         state <= seq_step(state);
    end

    assign word     = fixed ? pattern : state;
    assign tx_valid = en ? txmask : '0;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        assign tx_data[i*WORD_W +: WORD_W] = word;
    end

    // R2: the sequence state never collapses to the all-zero lock-up value.
    a_r2_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state != 32'd0);
endmodule

// File: rtl/lbist_check.sv
// Receive-side checker for the selected lane. Steps its expected sequence only
// on valid words and keeps a sticky pass flag and a wrapping compare count.
module lbist_check
    import lbist_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             en,
    input  logic             fixed,
    input  logic [31:0]      pattern,
    input  logic             rx_vld,
    input  logic [31:0]      rx_word,
    output logic             good,
    output logic [CNT_W-1:0] count
);
    logic [31:0] expect_q;
    logic        take;
    logic        miss;

    assign take = en && rx_vld;
    assign miss = rx_word != (fixed ? pattern : expect_q);

    // Expected sequence: reseed on start, step on each compared word.
    always_ff @(posedge clk) begin
        if (!rst_n || start) expect_q <= SEQ_SEED;
        else if (take)       expect_q <= seq_step(expect_q);
    end

    // Pass flag and compare count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good  <= 1'b0;
            count <= '0;
        end else if (start) begin
            good  <= 1'b1;
            count <= '0;
        end else if (take) begin
            count <= count + 1'b1;
            if (miss) good <= 1'b0;
        end
    end

    // R1: a start gives a passing, empty result.
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (good && count == '0));
    // R6: once low, the pass flag stays low until the next start.
    a_r6_good_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!good && !start) |=> !good);
    // R7: each compared word adds exactly one (modulo the count width).
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !start) |=> count == $past(count) + 1'b1);
    // R8: nothing moves while disabled.
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !start) |=> ($stable(count) && $stable(good)));
endmodule

// File: rtl/lbist_engine.sv
// Loopback self-test engine top: registers, word generator, lane select and
// checker, plus the register read mux. Assumes NLANES <= 16 and a power of two.
module lbist_engine
    import lbist_pkg::*;
#(
    parameter int NLANES = 4,
    localparam int SELW  = (NLANES > 1) ? $clog2(NLANES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr_en,
    input  logic [1:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic [NLANES-1:0]        tx_valid,
    output logic [NLANES*WORD_W-1:0] tx_data,
    input  logic [NLANES-1:0]        rx_valid,
    input  logic [NLANES*WORD_W-1:0] rx_data
);
    logic              en, fixed, start, good;
    logic [SELW-1:0]   rxsel;
    logic [NLANES-1:0] txmask;
    logic [31:0]       pattern;
    logic [CNT_W-1:0]  count;
    logic [31:0]       ctrl_view;

    lbist_regs #(.NLANES(NLANES), .SELW(SELW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .en(en), .fixed(fixed), .rxsel(rxsel),
        .txmask(txmask), .pattern(pattern), .start(start)
    );

    lbist_gen #(.NLANES(NLANES)) u_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .en(en), .fixed(fixed),
        .txmask(txmask), .pattern(pattern), .tx_valid(tx_valid),
        .tx_data(tx_data)
    );

    lbist_check u_check (
        .clk(clk), .rst_n(rst_n), .start(start), .en(en), .fixed(fixed),
        .pattern(pattern), .rx_vld(rx_valid[rxsel]),
        .rx_word(rx_data[rxsel*WORD_W +: WORD_W]), .good(good), .count(count)
    );

    // Build the control read-back view from the stored fields.
    always_comb begin
        ctrl_view                     = '0;
        ctrl_view[BIT_EN]             = en;
        ctrl_view[BIT_FIXED]          = fixed;
        ctrl_view[SEL_LSB +: SELW]    = rxsel;
        ctrl_view[NLANES-1:0]         = txmask;
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_view;
            ADDR_PAT:  reg_rdata = pattern;
            ADDR_STAT: reg_rdata = {good, {(31-CNT_W){1'b0}}, count};
            default:   reg_rdata = '0;
        endcase
    end

    // R4: no lane outside the mask ever strobes.
    a_r4_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid & ~txmask) == '0);
    // R3: in fixed mode the sent word is the pattern register.
    a_r3_fixed_word: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fixed) |-> tx_data[WORD_W-1:0] == pattern);
endmodule

// File: tb/lbist_engine_test.sv
`timescale 1ns/1ps
module lbist_engine_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [3:0]   tx_valid;
    logic [127:0] tx_data;
    logic [3:0]   rx_valid;
    logic [127:0] rx_data;

    logic         use_loop = 1'b0;
    logic [127:0] corrupt = '0;
    logic [3:0]   drv_valid = '0;
    logic [127:0] drv_data = '0;
    int           nchecks = 0;
    int           nerrors = 0;
    bit           done = 1'b0;

    localparam logic [31:0] SEED = 32'h1234_5678;

    assign rx_valid = use_loop ? tx_valid : drv_valid;
    assign rx_data  = use_loop ? (tx_data ^ corrupt) : drv_data;

    always #4 clk = ~clk;

    lbist_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    function automatic logic [31:0] model_step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd2, v); check("R9 reset status", v, 32'h0);
        rd(2'd0, v); check("R9 reset control", v, 32'h0);
        rd(2'd1, v); check("R9 reset pattern", v, 32'h0);
        check("R8 reset tx_valid", {28'h0, tx_valid}, 32'h0);
    endtask

    task automatic t_ctrl_readback();
        logic [31:0] v;
        wr(2'd0, 32'h7FFF_FFFF);
        rd(2'd0, v); check("R9 control field readback", v, 32'h4003_000F);
        check("R8 no strobes when not enabled", {28'h0, tx_valid}, 32'h0);
    endtask

    task automatic t_prbs_tx();
        logic [31:0] m = SEED;
        use_loop = 1'b0;
        wr(2'd0, 32'h8000_0005);
        check("R4 tx mask 0101", {28'h0, tx_valid}, 32'h5);
        for (int k = 0; k < 5; k++) begin
            check("R2 lane0 sequence", tx_data[31:0], m);
            check("R4 lane2 same word", tx_data[95:64], m);
            m = model_step(m);
            @(negedge clk);
        end
    endtask

    task automatic t_loop_count();
        logic [31:0] v;
        use_loop = 1'b1;
        wr(2'd0, 32'h8002_000F);
        repeat (10) @(negedge clk);
        rd(2'd2, v); check("R7 count after 10 looped words", v, 32'h8000_000A);
    endtask

    task automatic t_gaps();
        logic [31:0] v;
        logic [31:0] m = SEED;
        use_loop = 1'b0;
        wr(2'd0, 32'h8001_0000);
        for (int i = 0; i < 12; i++) begin
            if (i % 3 != 2) begin
                drv_valid = 4'b0011;
                drv_data[63:32] = m;
                drv_data[31:0]  = ~m;
                m = model_step(m);
            end else begin
                drv_valid = 4'b0001;
                drv_data[31:0] = 32'hBAD0_BAD0;
            end
            @(negedge clk);
        end
        drv_valid = '0;
        rd(2'd2, v); check("R5 gapped stream stays in step", v, 32'h8000_0008);
    endtask

    task automatic t_miscompare();
        logic [31:0] v;
        use_loop = 1'b1;
        wr(2'd0, 32'h8002_000F);
        repeat (3) @(negedge clk);
        corrupt[64 +: 32] = 32'h0000_0001;
        @(negedge clk);
        corrupt = '0;
        repeat (3) @(negedge clk);
        rd(2'd2, v); check("R6 pass flag cleared and sticky", v, 32'h0000_0007);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(2'd0, 32'h8002_000F);
        rd(2'd2, v); check("R1 restart clears result", v, 32'h8000_0000);
        repeat (2) @(negedge clk);
        rd(2'd2, v); check("R1 restart resynchronises", v, 32'h8000_0002);
    endtask

    task automatic t_lane_ignore();
        logic [31:0] v;
        corrupt[32 +: 32] = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        corrupt = '0;
        rd(2'd2, v); check("R5 unselected lane ignored", v, 32'h8000_0006);
    endtask

    task automatic t_fixed();
        logic [31:0] v;
        wr(2'd1, 32'hDEAD_BEEF);
        wr(2'd0, 32'hC002_000F);
        for (int k = 0; k < 3; k++) begin
            check("R3 lane0 fixed word", tx_data[31:0], 32'hDEAD_BEEF);
            check("R3 lane3 fixed word", tx_data[127:96], 32'hDEAD_BEEF);
            @(negedge clk);
        end
        rd(2'd2, v); check("R3 fixed loopback passes", v, 32'h8000_0003);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(2'd0, 32'h8002_000F);
        repeat (2050) @(negedge clk);
        rd(2'd2, v); check("R7 count wraps, pass flag kept", v, 32'h8000_0002);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        wr(2'd0, 32'h0002_000F);
        rd(2'd2, v); check("R8 final result on disable", v, 32'h8000_0004);
        check("R8 tx strobes off", {28'h0, tx_valid}, 32'h0);
        use_loop = 1'b0;
        drv_valid = 4'hF;
        drv_data = {4{32'h0BAD_F00D}};
        repeat (5) @(negedge clk);
        drv_valid = '0;
        rd(2'd2, v); check("R8 result frozen", v, 32'h8000_0004);
    endtask

    task automatic t_status_write();
        logic [31:0] v;
        wr(2'd2, 32'h0000_0000);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R9 status write ignored", v, 32'h8000_0004);
        rd(2'd1, v); check("R9 pattern readback", v, 32'hDEAD_BEEF);
        rd(2'd0, v); check("R9 control readback", v, 32'h0002_000F);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerrors++;
            nchecks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_readback();
        t_prbs_tx();
        t_loop_count();
        t_gaps();
        t_miscompare();
        t_restart();
        t_lane_ignore();
        t_fixed();
        t_wrap();
        t_freeze();
        t_status_write();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end
endmodule